// File: doc/BRIEF.md
# Precise Register State with Future File

This block holds two copies of a processor's register state so that results finishing out of order never spoil the state seen after an exception. A long operation such as a divide can finish after younger, shorter operations. Each result is written at once into a speculative copy, the future file. The pipeline reads its operands from the future file. A second copy, the architectural file, changes only in program order. It takes a result only when every instruction issued before it has finished.

Each issued instruction takes a slot in a circular completion queue. The slot number is returned as the instruction's tag. Execution units later report completion against that tag, with a result and an exception flag. The queue retires from its head, in order. When the head entry carries an exception, every in-flight entry is discarded and the future file is reloaded from the architectural file. A one-cycle recovery pulse then tells the pipeline it may restart from the precise point.

Top module: `precise_regstate`

## Requirements
- R1: After reset both register files read zero in every register, the queue is empty, `iss_ready` is 1 and `recov_done` is 0.
- R2: A completion without exception for an in-flight tag writes its result into the future file. The value appears on the operand read ports in the cycle after the completion, whatever the order of completion.
- R3: When two in-flight instructions target the same register, a completion from the older one does not overwrite a value already written by the younger one in the future file.
- R4: The architectural file takes results strictly in issue order, at most one per cycle. The queue head commits on the clock edge after its completion. An entry waits while any older entry is unfinished.
- R5: A completion whose tag is not held by an in-flight entry has no effect on either file or on the queue.
- R6: Tags are handed out in issue order as slot numbers 0 to DEPTH-1, wrapping to 0 after DEPTH-1. With DEPTH entries in flight, `iss_ready` is 0, an issue request is refused, and the next tag does not advance.
- R7: When the queue head is finished and flagged with an exception, one clock edge empties the queue and copies the architectural file into the future file. `recov_done` is 1 for exactly the following cycle. The result of the faulting instruction, and of younger instructions, never reaches either file after that.
- R8: An exception reported by a younger instruction does not stop older instructions from committing. Recovery waits until the faulting entry reaches the head.
- R9: In the cycle in which recovery is carried out, `iss_ready` is 0. In the cycle after it, `iss_ready` is 1 again and issue restarts at the tag that follows the last one handed out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_valid | input | 1 | Issue request for one instruction |
| iss_dst | input | AW | Destination register of the issuing instruction |
| iss_ready | output | 1 | Issue accepted this cycle when high |
| iss_tag | output | TW | Tag given to the instruction issued this cycle |
| cmp_valid | input | 1 | Completion report |
| cmp_tag | input | TW | Tag of the completing instruction |
| cmp_data | input | DW | Result value |
| cmp_exc | input | 1 | Completing instruction raised an exception |
| rd_addr_a | input | AW | Operand read address A (future file) |
| rd_data_a | output | DW | Operand read data A |
| rd_addr_b | input | AW | Operand read address B (future file) |
| rd_data_b | output | DW | Operand read data B |
| arch_addr | input | AW | Architectural file read address |
| arch_data | output | DW | Architectural file read data |
| recov_done | output | 1 | One-cycle pulse after exception recovery |

## Verification
The first pattern finishes a long operation after two younger ones. This separates the immediate future-file update from the held-back architectural commit, and shows the one-per-cycle commit order. A pattern of two writes to the same register, finishing youngest first, exposes any future file that simply takes the last arrival. A bogus completion and a run that fills all eight slots and then tries a ninth issue test the tag bookkeeping. A final pattern raises an exception on a middle instruction that has both an older slow instruction and a finished younger one. It shows the older result reaching the precise state, the younger result being undone, and the single recovery pulse.

// File: rtl/regstate_pkg.sv
package regstate_pkg;
    localparam int unsigned DEF_NREG  = 32;
    localparam int unsigned DEF_DW    = 32;
    localparam int unsigned DEF_DEPTH = 8;
endpackage

// File: rtl/rs_regfile.sv
module rs_regfile #(
    parameter int unsigned NREG = 32,
    parameter int unsigned DW   = 32,
    parameter int unsigned NRD  = 2,
    localparam int unsigned AW  = $clog2(NREG)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [AW-1:0]                 waddr,
    input  logic [DW-1:0]                 wdata,
    input  logic                          load,
    input  logic [NREG-1:0][DW-1:0]       load_img,
    input  logic [NRD-1:0][AW-1:0]        rd_addr,
    output logic [NRD-1:0][DW-1:0]        rd_data,
    output logic [NREG-1:0][DW-1:0]       img
);
    typedef struct packed {
        logic [NREG-1:0][DW-1:0] r;
    } rf_t;

    rf_t rf_d, rf_q;

    always_comb begin
        rf_d = rf_q;
        if (load) begin
            rf_d.r = load_img;
        end else if (we) begin
            rf_d.r[waddr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_data[g] = rf_q.r[rd_addr[g]];
    end

    assign img = rf_q.r;
endmodule

// File: rtl/rs_cqueue.sv
module rs_cqueue #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned AW    = 5,
    parameter int unsigned DW    = 32,
    localparam int unsigned TW   = $clog2(DEPTH),
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_dst,
    input  logic          pop,
    input  logic          flush,
    input  logic          cmp_valid,
    input  logic [TW-1:0] cmp_tag,
    input  logic [DW-1:0] cmp_data,
    input  logic          cmp_exc,
    output logic [TW-1:0] tail,
    output logic          full,
    output logic [CW-1:0] count,
    output logic          head_valid,
    output logic          head_done,
    output logic          head_exc,
    output logic [AW-1:0] head_dst,
    output logic [DW-1:0] head_data,
    output logic          cmp_hit,
    output logic [AW-1:0] cmp_dst
);
    typedef struct packed {
        logic [DEPTH-1:0]         vld;
        logic [DEPTH-1:0]         dn;
        logic [DEPTH-1:0]         ex;
        logic [DEPTH-1:0][AW-1:0] dst;
        logic [DEPTH-1:0][DW-1:0] dat;
        logic [TW-1:0]            head;
        logic [TW-1:0]            tail;
        logic [CW-1:0]            cnt;
    } q_t;

    q_t st_d, st_q;

    assign cmp_hit = cmp_valid && st_q.vld[cmp_tag] && !st_q.dn[cmp_tag];
    assign cmp_dst = st_q.dst[cmp_tag];

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.vld  = '0;
            st_d.dn   = '0;
            st_d.ex   = '0;
            st_d.head = st_q.tail;
            st_d.cnt  = '0;
        end else begin
            if (cmp_hit) begin
                st_d.dn[cmp_tag]  = 1'b1;
                st_d.ex[cmp_tag]  = cmp_exc;
                st_d.dat[cmp_tag] = cmp_data;
            end
            if (pop) begin
                st_d.vld[st_q.head] = 1'b0;
                st_d.dn[st_q.head]  = 1'b0;
                st_d.head           = st_q.head + 1'b1;
            end
            if (push) begin
                st_d.vld[st_q.tail] = 1'b1;
                st_d.dn[st_q.tail]  = 1'b0;
                st_d.ex[st_q.tail]  = 1'b0;
                st_d.dst[st_q.tail] = push_dst;
                st_d.tail           = st_q.tail + 1'b1;
            end
            st_d.cnt = st_q.cnt + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tail       = st_q.tail;
    assign count      = st_q.cnt;
    assign full       = (st_q.cnt == CW'(DEPTH));
    assign head_valid = st_q.vld[st_q.head];
    assign head_done  = st_q.dn[st_q.head];
    assign head_exc   = st_q.ex[st_q.head];
    assign head_dst   = st_q.dst[st_q.head];
    assign head_data  = st_q.dat[st_q.head];
endmodule

// File: rtl/precise_regstate.sv
module precise_regstate #(
    parameter int unsigned NREG  = regstate_pkg::DEF_NREG,
    parameter int unsigned DW    = regstate_pkg::DEF_DW,
    parameter int unsigned DEPTH = regstate_pkg::DEF_DEPTH,
    localparam int unsigned AW   = $clog2(NREG),
    localparam int unsigned TW   = $clog2(DEPTH),
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          iss_valid,
    input  logic [AW-1:0] iss_dst,
    output logic          iss_ready,
    output logic [TW-1:0] iss_tag,
    input  logic          cmp_valid,
    input  logic [TW-1:0] cmp_tag,
    input  logic [DW-1:0] cmp_data,
    input  logic          cmp_exc,
    input  logic [AW-1:0] rd_addr_a,
    output logic [DW-1:0] rd_data_a,
    input  logic [AW-1:0] rd_addr_b,
    output logic [DW-1:0] rd_data_b,
    input  logic [AW-1:0] arch_addr,
    output logic [DW-1:0] arch_data,
    output logic          recov_done
);
    typedef struct packed {
        logic [NREG-1:0][TW-1:0] last;
        logic                    rdone;
    } top_t;

    top_t st_d, st_q;

    logic          push, pop, flush, q_full;
    logic [CW-1:0] q_count;
    logic          head_valid, head_done, head_exc, cmp_hit;
    logic [AW-1:0] head_dst, cmp_dst;
    logic [DW-1:0] head_data;
    logic          ff_we;
    logic [NREG-1:0][DW-1:0] arch_img, fut_img;
    logic [1:0][AW-1:0] fut_addr;
    logic [1:0][DW-1:0] fut_data;
    logic [0:0][AW-1:0] arc_addr;
    logic [0:0][DW-1:0] arc_data;

    assign flush     = head_valid && head_done && head_exc;
    assign pop       = head_valid && head_done && !head_exc;
    assign iss_ready = !q_full && !flush;
    assign push      = iss_valid && iss_ready;
    assign ff_we     = cmp_hit && !cmp_exc && !flush &&
                       (st_q.last[cmp_dst] == cmp_tag);

    always_comb begin
        st_d       = st_q;
        st_d.rdone = flush;
        if (push) st_d.last[iss_dst] = iss_tag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    rs_cqueue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_queue (
        .clk, .rst_n,
        .push, .push_dst(iss_dst), .pop, .flush,
        .cmp_valid, .cmp_tag, .cmp_data, .cmp_exc,
        .tail(iss_tag), .full(q_full), .count(q_count),
        .head_valid, .head_done, .head_exc, .head_dst, .head_data,
        .cmp_hit, .cmp_dst
    );

    assign fut_addr = {rd_addr_b, rd_addr_a};
    rs_regfile #(.NREG(NREG), .DW(DW), .NRD(2)) u_future (
        .clk, .rst_n,
        .we(ff_we), .waddr(cmp_dst), .wdata(cmp_data),
        .load(flush), .load_img(arch_img),
        .rd_addr(fut_addr), .rd_data(fut_data), .img(fut_img)
    );
    assign rd_data_a = fut_data[0];
    assign rd_data_b = fut_data[1];

    assign arc_addr[0] = arch_addr;
    rs_regfile #(.NREG(NREG), .DW(DW), .NRD(1)) u_arch (
        .clk, .rst_n,
        .we(pop), .waddr(head_dst), .wdata(head_data),
        .load(1'b0), .load_img(fut_img),
        .rd_addr(arc_addr), .rd_data(arc_data), .img(arch_img)
    );
    assign arch_data  = arc_data[0];
    assign recov_done = st_q.rdone;
endmodule

// File: rtl/precise_regstate_chk.sv
module precise_regstate_chk #(
    parameter int unsigned NREG  = 32,
    parameter int unsigned DW    = 32,
    parameter int unsigned DEPTH = 8,
    localparam int unsigned TW   = $clog2(DEPTH),
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    iss_valid,
    input logic                    iss_ready,
    input logic [TW-1:0]           iss_tag,
    input logic                    recov_done,
    input logic                    flush,
    input logic [CW-1:0]           q_count,
    input logic [NREG-1:0][DW-1:0] arch_img
);
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= CW'(DEPTH)); // R6
    AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        (q_count == CW'(DEPTH)) |-> !iss_ready); // R6
    AST_REFUSED_TAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_ready) |=> $stable(iss_tag)); // R6
    AST_ARCH_QUIET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (q_count == '0) |=> $stable(arch_img)); // R4
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (q_count == '0 && recov_done)); // R7
    AST_RECOV_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        recov_done |=> !recov_done); // R7
    AST_NO_ISSUE_IN_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !iss_ready); // R9
endmodule

bind precise_regstate precise_regstate_chk #(.NREG(NREG), .DW(DW), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_tag(iss_tag), .recov_done(recov_done), .flush(flush),
    .q_count(q_count), .arch_img(arch_img)
);

// File: tb/precise_regstate_tb.sv
module precise_regstate_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 5;
    localparam int TW = 3;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          iss_valid = 1'b0;
    logic [AW-1:0] iss_dst = '0;
    logic          iss_ready;
    logic [TW-1:0] iss_tag;
    logic          cmp_valid = 1'b0;
    logic [TW-1:0] cmp_tag = '0;
    logic [DW-1:0] cmp_data = '0;
    logic          cmp_exc = 1'b0;
    logic [AW-1:0] rd_addr_a = '0, rd_addr_b = '0, arch_addr = '0;
    logic [DW-1:0] rd_data_a, rd_data_b, arch_data;
    logic          recov_done;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    int          kind_q[$];
    int          addr_q[$];
    logic [31:0] val_q[$];
    string       req_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    precise_regstate u_dut (.*);

    // driver side: record an expected observation
    task automatic expect_v(input int kind, input int addr, input logic [31:0] val, input string req);
        kind_q.push_back(kind); addr_q.push_back(addr);
        val_q.push_back(val);   req_q.push_back(req);
    endtask

    // monitor side: observe the ports and compare against the queued items
    task automatic drain();
        while (kind_q.size() > 0) begin
            int k = kind_q.pop_front();
            int a = addr_q.pop_front();
            logic [31:0] e = val_q.pop_front();
            string r = req_q.pop_front();
            logic [31:0] act;
            case (k)
                0: begin rd_addr_a = AW'(a); #1; act = rd_data_a; end
                1: begin rd_addr_b = AW'(a); #1; act = rd_data_b; end
                2: begin arch_addr = AW'(a); #1; act = arch_data; end
                3: act = {31'b0, iss_ready};
                default: act = {31'b0, recov_done};
            endcase
            vectors++;
            if (act !== e) begin
                miscompares++;
                $display("FAIL %s kind=%0d addr=%0d actual=%h expected=%h", r, k, a, act, e);
            end
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic issue(input int dst, output int tag);
        @(negedge clk);
        iss_valid = 1'b1; iss_dst = AW'(dst);
        #1 tag = int'(iss_tag);
        @(posedge clk); #1;
        iss_valid = 1'b0;
    endtask

    task automatic complete(input int tag, input logic [31:0] data, input logic exc);
        @(negedge clk);
        cmp_valid = 1'b1; cmp_tag = TW'(tag); cmp_data = data; cmp_exc = exc;
        @(posedge clk); #1;
        cmp_valid = 1'b0; cmp_exc = 1'b0;
    endtask

    task automatic check_tag(input int got, input int exp, input string req);
        vectors++;
        if (got != exp) begin
            miscompares++;
            $display("FAIL %s tag actual=%0d expected=%0d", req, got, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        miscompares++;
        $display("FAIL watchdog actual=timeout expected=finish");
        if (!finished) $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        int t;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();

        // R1: reset state
        for (int i = 0; i < 4; i++) begin
            expect_v(0, i, 32'h0, "R1");
            expect_v(2, i, 32'h0, "R1");
        end
        expect_v(3, 0, 32'h1, "R1");
        expect_v(4, 0, 32'h0, "R1");
        drain();

        // R2/R4: slow op finishes after two younger ones
        issue(1, t); check_tag(t, 0, "R6");
        issue(2, t); check_tag(t, 1, "R6");
        issue(3, t); check_tag(t, 2, "R6");
        complete(2, 32'h33, 1'b0);
        expect_v(0, 3, 32'h33, "R2");
        expect_v(2, 3, 32'h0, "R4");
        drain();
        complete(1, 32'h22, 1'b0);
        expect_v(1, 2, 32'h22, "R2");
        expect_v(2, 2, 32'h0, "R4");
        drain();
        complete(0, 32'h11, 1'b0);
        expect_v(0, 1, 32'h11, "R2");
        expect_v(2, 1, 32'h0, "R4");
        drain();
        tick();
        expect_v(2, 1, 32'h11, "R4");
        expect_v(2, 2, 32'h0, "R4");
        drain();
        tick();
        expect_v(2, 2, 32'h22, "R4");
        expect_v(2, 3, 32'h0, "R4");
        drain();
        tick();
        expect_v(2, 3, 32'h33, "R4");
        drain();

        // R3: two writers of r5, younger finishes first
        issue(5, t); check_tag(t, 3, "R6");
        issue(5, t); check_tag(t, 4, "R6");
        complete(4, 32'h55, 1'b0);
        expect_v(0, 5, 32'h55, "R3");
        drain();
        complete(3, 32'h44, 1'b0);
        expect_v(0, 5, 32'h55, "R3");
        drain();
        tick();
        expect_v(2, 5, 32'h44, "R4");
        drain();
        tick();
        expect_v(2, 5, 32'h55, "R4");
        drain();

        // R5: completion for a tag that is not in flight
        complete(6, 32'h99, 1'b0);
        expect_v(0, 0, 32'h0, "R5");
        drain();
        tick();
        expect_v(2, 0, 32'h0, "R5");
        drain();
        issue(7, t); check_tag(t, 5, "R6");
        issue(8, t); check_tag(t, 6, "R6");
        tick(); tick();
        expect_v(0, 8, 32'h0, "R5");
        expect_v(2, 8, 32'h0, "R5");
        expect_v(2, 7, 32'h0, "R5");
        drain();
        complete(6, 32'h88, 1'b0);
        complete(5, 32'h77, 1'b0);
        tick(); tick();
        expect_v(2, 7, 32'h77, "R4");
        expect_v(2, 8, 32'h88, "R4");
        drain();

        // R6: fill all slots, wrap the tag, refuse a ninth issue
        for (int i = 0; i < 8; i++) begin
            issue(10 + i, t);
            check_tag(t, (7 + i) % 8, "R6");
        end
        expect_v(3, 0, 32'h0, "R6");
        drain();
        issue(31, t); check_tag(t, 7, "R6");
        expect_v(3, 0, 32'h0, "R6");
        expect_v(0, 31, 32'h0, "R6");
        drain();
        for (int i = 0; i < 8; i++) complete((7 + i) % 8, 32'h100 + i, 1'b0);
        tick();
        expect_v(2, 10, 32'h100, "R4");
        expect_v(2, 17, 32'h107, "R4");
        expect_v(2, 31, 32'h0, "R6");
        expect_v(3, 0, 32'h1, "R6");
        drain();

        // R7/R8/R9: exception in the middle of three
        issue(20, t); check_tag(t, 7, "R6");
        issue(21, t); check_tag(t, 0, "R6");
        issue(22, t); check_tag(t, 1, "R6");
        complete(1, 32'hC2, 1'b0);
        expect_v(1, 22, 32'hC2, "R2");
        drain();
        complete(0, 32'hBAD, 1'b1);
        expect_v(0, 21, 32'h0, "R7");
        drain();
        complete(7, 32'hA0, 1'b0);
        expect_v(4, 0, 32'h0, "R8");
        drain();
        tick();
        expect_v(2, 20, 32'hA0, "R8");
        expect_v(3, 0, 32'h0, "R9");
        expect_v(4, 0, 32'h0, "R7");
        drain();
        tick();
        expect_v(4, 0, 32'h1, "R7");
        expect_v(0, 22, 32'h0, "R7");
        expect_v(0, 20, 32'hA0, "R7");
        expect_v(1, 1, 32'h11, "R7");
        expect_v(2, 21, 32'h0, "R7");
        drain();
        tick();
        expect_v(4, 0, 32'h0, "R7");
        expect_v(3, 0, 32'h1, "R9");
        expect_v(2, 22, 32'h0, "R7");
        drain();
        issue(22, t); check_tag(t, 2, "R9");
        complete(2, 32'hD0, 1'b0);
        tick();
        expect_v(2, 22, 32'hD0, "R9");
        expect_v(0, 22, 32'hD0, "R2");
        drain();

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule